// File: doc/BRIEF.md
# Instruction Fetch Burst Requester

This block sits between an instruction cache controller and a read-only system bus port. On a demand miss it issues one read request for the 32-byte line that holds the missing address. The controller may also ask for up to two following lines as a speculative fill. The block then issues a single quadword burst that covers the demand line and those extra lines. It shortens the burst so that it stays inside the current 4 KB page.

The downstream data bus may be 32, 64 or 128 bits wide; this is chosen by a parameter. Returned data is packed into 128-bit quadwords. Each quadword is tagged with its line number and its quadword number inside the line, and the final quadword of the burst is flagged. Up to three acknowledged requests can wait for their data at once, and data returns in request order.

A flush from the controller cuts the speculative part of the burst that is receiving data. The demand line still completes normally.

Top module: `ifetch_burst_req`

## Requirements
- R1: A miss presented while `miss_ready` is high is accepted on that clock edge. From the next cycle `bus_req` is high with `bus_addr` equal to the miss address with bits [4:0] cleared. Address and length hold steady until the edge where `bus_addr_ack` is high.
- R2: `bus_nqw` gives the burst length in quadwords as 2 × (1 + extra). `extra` is the number of speculative lines asked for on `miss_spec` (0, 1 or 2; the code 3 counts as 2), reduced as R3 requires.
- R3: A burst never crosses a 4 KB boundary: `extra` is at most 127 minus address bits [11:5].
- R4: Each quadword is built from 128/BUS_W data beats. The first beat fills bits [BUS_W-1:0] and later beats fill higher slices in order. `qw_valid` is high for one cycle, in the cycle after the edge that takes the final beat.
- R5: Quadwords of a burst are delivered in order. For the quadword with number b (counting from 0), `qw_line` = b/2 and `qw_idx` = b mod 2.
- R6: `qw_last` is high with the final quadword of each burst and with no other quadword.
- R7: Up to three acknowledged requests may wait for their data. `miss_ready` is low while a request waits for its address acknowledge, or while three requests have data still owed.
- R8: Address acknowledge and the first data beat may come on the same edge as the one that completes the request. The beat is then counted as the first beat of that request.
- R9: A flush while a burst has data owed stops delivery of that burst's quadwords with line number 1 or 2. The owed beats are still taken from the bus. If the demand line's second quadword is not yet delivered, it carries `qw_last`. Later bursts are unaffected, and a flush with no data owed has no effect.
- R10: After reset `bus_req` and `qw_valid` are low and `miss_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request from the cache controller |
| miss_addr | input | 36 | Miss byte address |
| miss_spec | input | 2 | Number of speculative lines wanted (0 to 2; 3 counts as 2) |
| miss_ready | output | 1 | A miss can be accepted |
| flush | input | 1 | Drop the speculative quadwords of the burst receiving data |
| bus_req | output | 1 | Read request to the bus |
| bus_addr | output | 36 | Line-aligned request address |
| bus_nqw | output | 3 | Burst length in quadwords (2, 4 or 6) |
| bus_addr_ack | input | 1 | Bus accepts the request |
| bus_data_ack | input | 1 | Read data beat valid |
| bus_rd_data | input | BUS_W | Read data beat |
| qw_valid | output | 1 | Assembled quadword valid |
| qw_data | output | 128 | Assembled quadword |
| qw_line | output | 2 | Line number within the burst |
| qw_idx | output | 1 | Quadword number within the line |
| qw_last | output | 1 | Final delivered quadword of the burst |

## Verification
The bench sweeps the line positions at the start of a page and just below a page end against every speculative code. This exposes a page clamp that is off by one line, which would request a line from the next page or drop one that fits. Three bursts are acknowledged before any data returns. This catches a queue that mixes up the lengths or tags of queued bursts, or that lets a fourth miss in. A request whose address acknowledge and first data beat come on the same edge shows whether a design loses that beat or tags it to nothing. Flushes are sent between the two demand quadwords, while idle, and before a following burst. They catch a design that drops demand data, leaves the last flag missing, or keeps the flush set into the next burst.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
    localparam int QW_W   = 128;
    localparam int ADDR_W = 36;

    typedef logic [1:0] xline_t;
endpackage

// File: rtl/ifb_req_queue.sv
module ifb_req_queue
    import ifb_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  xline_t                       push_extra,
    input  logic                         pop,
    output xline_t                       head_extra,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        xline_t [DEPTH-1:0] mem;
        logic   [PW-1:0]    wr;
        logic   [PW-1:0]    rd;
        logic   [CW-1:0]    cnt;
    } q_t;

    q_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.mem[q_q.wr] = push_extra;
            q_d.wr = (q_q.wr == PW'(DEPTH - 1)) ? '0 : q_q.wr + 1'b1;
        end
        if (pop) begin
            q_d.rd = (q_q.rd == PW'(DEPTH - 1)) ? '0 : q_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    // Empty queue: the entry being pushed is the head (zero-latency data).
    assign head_extra = (q_q.cnt == '0) ? push_extra : q_q.mem[q_q.rd];
    assign count      = q_q.cnt;
endmodule

// File: rtl/ifb_assembler.sv
module ifb_assembler
    import ifb_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  logic [BUS_W-1:0] beat_data,
    output logic             qw_done,
    output logic [QW_W-1:0]  qw_word
);
    localparam int NPIECE = QW_W / BUS_W;

    generate
        if (NPIECE == 1) begin : g_wide
            assign qw_done = beat_valid;
            assign qw_word = beat_data;
        end else begin : g_narrow
            localparam int SW = $clog2(NPIECE);
            localparam int BW = (NPIECE - 1) * BUS_W;

            logic [SW-1:0] sub_d, sub_q;
            logic [BW-1:0] buf_d, buf_q;

            always_comb begin
                sub_d = sub_q;
                buf_d = buf_q;
                if (beat_valid) begin
                    sub_d = (sub_q == SW'(NPIECE - 1)) ? '0 : sub_q + 1'b1;
                    buf_d = BW'({beat_data, buf_q} >> BUS_W);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sub_q <= '0;
                    buf_q <= '0;
                end else begin
                    sub_q <= sub_d;
                    buf_q <= buf_d;
                end
            end

            assign qw_done = beat_valid && (sub_q == SW'(NPIECE - 1));
            assign qw_word = {beat_data, buf_q};
        end
    endgenerate
endmodule

// File: rtl/ifetch_burst_req.sv
module ifetch_burst_req
    import ifb_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [1:0]        miss_spec,
    output logic              miss_ready,
    input  logic              flush,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_nqw,
    input  logic              bus_addr_ack,
    input  logic              bus_data_ack,
    input  logic [BUS_W-1:0]  bus_rd_data,
    output logic              qw_valid,
    output logic [QW_W-1:0]   qw_data,
    output logic [1:0]        qw_line,
    output logic              qw_idx,
    output logic              qw_last
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
        xline_t            extra;
        logic [2:0]        bidx;
        logic              flushed;
        logic              qv;
        logic [QW_W-1:0]   qdata;
        logic [1:0]        qline;
        logic              qidx;
        logic              qlast;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0]  outst;
    xline_t         head_extra;
    logic           qw_done;
    logic [QW_W-1:0] qw_word;
    logic           push, pop, accept, flush_eff, fin, deliver;
    logic [6:0]     room;
    xline_t         spec_c, extra_new;

    ifb_req_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_extra (st_q.extra),
        .pop        (pop),
        .head_extra (head_extra),
        .count      (outst)
    );

    ifb_assembler #(.BUS_W(BUS_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (bus_data_ack),
        .beat_data  (bus_rd_data),
        .qw_done    (qw_done),
        .qw_word    (qw_word)
    );

    always_comb begin
        st_d = st_q;

        miss_ready = !st_q.pend && (outst < CW'(DEPTH));
        accept     = miss_valid && miss_ready;
        push       = st_q.pend && bus_addr_ack;

        // Speculative lines, clamped to the code range and to the page end.
        room      = 7'h7F - miss_addr[11:5];
        spec_c    = (miss_spec == 2'd3) ? 2'd2 : miss_spec;
        extra_new = ({5'b0, spec_c} > room) ? room[1:0] : spec_c;

        fin       = qw_done && (st_q.bidx == {head_extra, 1'b1});
        pop       = fin;
        flush_eff = st_q.flushed || (flush && ((outst != '0) || push));
        deliver   = qw_done && !(flush_eff && (st_q.bidx[2:1] != 2'd0));

        if (push) st_d.pend = 1'b0;
        if (accept) begin
            st_d.pend  = 1'b1;
            st_d.addr  = {miss_addr[ADDR_W-1:5], 5'b0};
            st_d.extra = extra_new;
        end

        if (fin)          st_d.bidx = '0;
        else if (qw_done) st_d.bidx = st_q.bidx + 1'b1;
        st_d.flushed = fin ? 1'b0 : flush_eff;

        st_d.qv = deliver;
        if (deliver) begin
            st_d.qdata = qw_word;
            st_d.qline = st_q.bidx[2:1];
            st_d.qidx  = st_q.bidx[0];
            st_d.qlast = fin || (flush_eff && (st_q.bidx == 3'd1));
        end else begin
            st_d.qlast = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_req  = st_q.pend;
    assign bus_addr = st_q.addr;
    assign bus_nqw  = {st_q.extra, 1'b0} + 3'd2;
    assign qw_valid = st_q.qv;
    assign qw_data  = st_q.qdata;
    assign qw_line  = st_q.qline;
    assign qw_idx   = st_q.qidx;
    assign qw_last  = st_q.qlast;
endmodule

// File: rtl/ifb_checker.sv
module ifb_checker #(
    parameter int DEPTH = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       miss_valid,
    input logic                       miss_ready,
    input logic                       bus_req,
    input logic [35:0]                bus_addr,
    input logic [2:0]                 bus_nqw,
    input logic                       bus_addr_ack,
    input logic                       qw_valid,
    input logic [1:0]                 qw_line,
    input logic                       qw_last,
    input logic [$clog2(DEPTH+1)-1:0] outstanding
);
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready |=> bus_req);

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_addr_ack |=> bus_req && $stable(bus_addr) && $stable(bus_nqw));

    a_r1_align: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_addr[4:0] == 5'd0);

    a_r2_len: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_nqw == 3'd2 || bus_nqw == 3'd4 || bus_nqw == 3'd6));

    a_r3_page: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ({1'b0, bus_addr[11:5]} + {6'b0, bus_nqw[2:1]}) <= 8'd128);

    a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= ($clog2(DEPTH+1))'(DEPTH));

    a_r7_ready: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding == ($clog2(DEPTH+1))'(DEPTH) |-> !miss_ready);

    a_r5_line: assert property (@(posedge clk) disable iff (!rst_n)
        qw_valid |-> qw_line != 2'd3);

    a_r6_last: assert property (@(posedge clk) disable iff (!rst_n)
        qw_last |-> qw_valid);
endmodule

bind ifetch_burst_req ifb_checker #(.DEPTH(DEPTH)) u_ifb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .bus_req      (bus_req),
    .bus_addr     (bus_addr),
    .bus_nqw      (bus_nqw),
    .bus_addr_ack (bus_addr_ack),
    .qw_valid     (qw_valid),
    .qw_line      (qw_line),
    .qw_last      (qw_last),
    .outstanding  (outst)
);

// File: tb/test_ifetch_burst_req.sv
`timescale 1ns/1ps
module test_ifetch_burst_req;
    localparam int BW = 32;
    localparam int NP = 128 / BW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic [35:0]  miss_addr = '0;
    logic [1:0]   miss_spec = '0;
    logic         miss_ready;
    logic         flush = 1'b0;
    logic         bus_req;
    logic [35:0]  bus_addr;
    logic [2:0]   bus_nqw;
    logic         bus_addr_ack = 1'b0;
    logic         bus_data_ack = 1'b0;
    logic [BW-1:0] bus_rd_data = '0;
    logic         qw_valid;
    logic [127:0] qw_data;
    logic [1:0]   qw_line;
    logic         qw_idx;
    logic         qw_last;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ifetch_burst_req #(.BUS_W(BW), .DEPTH(3)) i_ifetch_burst_req (.*);

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mkqw(int s);
        logic [127:0] w;
        for (int k = 0; k < 4; k++)
            w[k*32 +: 32] = (32'(s) * 32'h0101_0101) ^ (32'(k) << 28) ^ 32'hC3A5_0000;
        return w;
    endfunction

    function automatic logic [35:0] maddr(int line);
        return {24'h5A3C91, 7'(line), 5'h17};
    endfunction

    function automatic int exp_extra(int line, int spec);
        int s = (spec > 2) ? 2 : spec;
        int r = 127 - line;
        return (s > r) ? r : s;
    endfunction

    task automatic issue(int line, int spec);
        chk("R7 miss_ready before issue", 128'(miss_ready), 128'(1));
        miss_valid = 1'b1;
        miss_addr  = maddr(line);
        miss_spec  = 2'(spec);
        @(posedge clk); @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic ack_req(int line, int nqw);
        chk("R1 bus_req", 128'(bus_req), 128'(1));
        chk("R1 bus_addr aligned", 128'(bus_addr), 128'({24'h5A3C91, 7'(line), 5'h0}));
        chk("R2 R3 bus_nqw", 128'(bus_nqw), 128'(nqw));
        bus_addr_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_addr_ack = 1'b0;
    endtask

    task automatic send_qw(int seed, int from, bit ev, int eline, int eidx, bit elast);
        logic [127:0] w = mkqw(seed);
        for (int j = from; j < NP; j++) begin
            bus_data_ack = 1'b1;
            bus_rd_data  = w[j*BW +: BW];
            @(posedge clk); @(negedge clk);
        end
        bus_data_ack = 1'b0;
        if (ev) begin
            chk("R4 qw_valid", 128'(qw_valid), 128'(1));
            chk("R4 qw_data", qw_data, w);
            chk("R5 qw_line", 128'(qw_line), 128'(eline));
            chk("R5 qw_idx", 128'(qw_idx), 128'(eidx));
            chk("R6 qw_last", 128'(qw_last), 128'(elast));
        end else begin
            chk("R9 flushed beat hidden", 128'(qw_valid), 128'(0));
        end
    endtask

    task automatic data_all(int seed, int n);
        for (int b = 0; b < n; b++)
            send_qw(seed + b, 0, 1'b1, b / 2, b % 2, b == n - 1);
    endtask

    initial begin
        int lines[6] = '{0, 1, 2, 125, 126, 127};
        int n;
        repeat (3) @(negedge clk);
        chk("R10 bus_req in reset", 128'(bus_req), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 bus_req", 128'(bus_req), 128'(0));
        chk("R10 qw_valid", 128'(qw_valid), 128'(0));
        chk("R10 miss_ready", 128'(miss_ready), 128'(1));

        // R2 R3 sweep of page positions against speculative codes
        foreach (lines[i]) begin
            for (int sp = 0; sp < 4; sp++) begin
                n = 2 * (1 + exp_extra(lines[i], sp));
                issue(lines[i], sp);
                ack_req(lines[i], n);
                data_all(100 * i + 10 * sp, n);
            end
        end

        // R7 three acknowledged requests pipelined ahead of data
        issue(10, 2); ack_req(10, 6);
        issue(20, 0); ack_req(20, 2);
        issue(30, 1); ack_req(30, 4);
        chk("R7 miss_ready low at three outstanding", 128'(miss_ready), 128'(0));
        data_all(700, 6);
        chk("R7 miss_ready back after first burst", 128'(miss_ready), 128'(1));
        data_all(710, 2);
        data_all(720, 4);

        // R8 address ack and first data beat on one edge
        issue(40, 1);
        begin
            logic [127:0] w = mkqw(800);
            bus_addr_ack = 1'b1;
            bus_data_ack = 1'b1;
            bus_rd_data  = w[BW-1:0];
            @(posedge clk); @(negedge clk);
            bus_addr_ack = 1'b0;
        end
        send_qw(800, 1, 1'b1, 0, 0, 1'b0);
        send_qw(801, 0, 1'b1, 0, 1, 1'b0);
        send_qw(802, 0, 1'b1, 1, 0, 1'b0);
        send_qw(803, 0, 1'b1, 1, 1, 1'b1);
        chk("R8 queue drained", 128'(miss_ready), 128'(1));

        // R9 flush between demand quadwords
        issue(50, 2); ack_req(50, 6);
        send_qw(900, 0, 1'b1, 0, 0, 1'b0);
        flush = 1'b1;
        @(posedge clk); @(negedge clk);
        flush = 1'b0;
        send_qw(901, 0, 1'b1, 0, 1, 1'b1);
        for (int b = 2; b < 6; b++) send_qw(900 + b, 0, 1'b0, 0, 0, 1'b0);
        chk("R9 ready after flushed burst", 128'(miss_ready), 128'(1));
        // later burst unaffected
        issue(60, 2); ack_req(60, 6);
        data_all(950, 6);
        // flush while idle has no effect
        flush = 1'b1;
        @(posedge clk); @(negedge clk);
        flush = 1'b0;
        issue(70, 1); ack_req(70, 4);
        data_all(980, 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule